// File: doc/BRIEF.md
# Redundant Store Commit Guard

This block sits between two cores that run the same thread in lockstep-free redundancy and the single memory commit port. Each core hands over its stores through its own valid/ready channel, and the block keeps them in a short queue per side. Loads, register results and branch outcomes never reach this block. A store is written to memory only when the oldest pending store on both sides agrees. Until then it is held, so one core may run a few stores ahead of the other.

When the two oldest stores differ, nothing is committed. Both queues are emptied, a one-cycle rollback pulse goes to both cores, and both store channels stay closed until the cores report that the earlier context is back in place. Snapshot requests from the cores are granted only while both queues are empty, so every store before a checkpoint has already been verified and written. A saturating count of detected disagreements is available as an output.

Top module: `store_pair_checker`

## Requirements
- R1: After reset both store channels are ready, no commit is offered, rollback is low and the disagreement count is zero.
- R2: Each side holds at most DEPTH (default 4) unpaired stores. Its ready is low while its queue is full, and no store is lost.
- R3: A pair is offered on the commit port (mem_valid high, carrying the stored address, data and byte enables) only when both oldest stores are equal in address, data and byte enables. It is held until mem_ready, and stores commit in the order they were issued.
- R4: A difference in any one of address, data or byte enables blocks the commit in that cycle. Both queues are emptied, so no stale store survives the recovery.
- R5: The cycle after a difference is found, rollback is high for exactly one cycle.
- R6: From the rollback pulse until restore_done is seen, both ready outputs and mem_valid stay low. The cycle after restore_done, both channels are ready again.
- R7: ckpt_grant is high in the same cycle as ckpt_req only when both queues are empty and no recovery is in progress. It is low while any unpaired store is pending.
- R8: The disagreement count rises by one per detected difference and stays at its all-ones value once reached (default width 8).
- R9: Stores from a side that is ahead are held without any commit until the matching store from the other side arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Core A store offered |
| a_ready | output | 1 | Core A store accepted |
| a_addr | input | ADDR_W | Core A store address |
| a_data | input | DATA_W | Core A store data |
| a_be | input | DATA_W/8 | Core A byte enables |
| b_valid | input | 1 | Core B store offered |
| b_ready | output | 1 | Core B store accepted |
| b_addr | input | ADDR_W | Core B store address |
| b_data | input | DATA_W | Core B store data |
| b_be | input | DATA_W/8 | Core B byte enables |
| mem_valid | output | 1 | Verified store offered to memory |
| mem_ready | input | 1 | Memory takes the store |
| mem_addr | output | ADDR_W | Committed address |
| mem_data | output | DATA_W | Committed data |
| mem_be | output | DATA_W/8 | Committed byte enables |
| ckpt_req | input | 1 | Cores ask to take a context snapshot |
| ckpt_grant | output | 1 | Snapshot may be taken this cycle |
| rollback | output | 1 | One-cycle pulse: restore saved context |
| restore_done | input | 1 | Cores report context restored |
| fault_count | output | CNT_W | Saturating count of disagreements |

## Verification
A long random run sends identical store streams to both sides with independent random gaps and random memory back-pressure. This separates correct pairing and ordering from mere lockstep matching. A directed run fills one side while the other is silent, which shows the run-ahead limit and that nothing is committed early. Faults are then injected separately in the address, the data and the byte enables, so a comparator that ignores one field is exposed. After each fault the bench checks the pulse, the closed channels, that a checkpoint is granted right after recovery (proving both queues were emptied), and the count up to and past saturation.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } store_t;

    typedef enum logic [0:0] {
        S_RUN  = 1'b0,
        S_HOLD = 1'b1
    } guard_state_e;
endpackage

// File: rtl/spc_fifo.sv
module spc_fifo
    import spc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  store_t din,
    input  logic   pop,
    input  logic   flush,
    output store_t head,
    output logic   empty,
    output logic   full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        store_t [DEPTH-1:0] mem;
        logic [PW-1:0]      wr;
        logic [PW-1:0]      rd;
        logic [CW-1:0]      cnt;
    } fifo_state_t;

    fifo_state_t q, d;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (push) begin
                d.mem[q.wr] = din;
                d.wr        = step(q.wr);
            end
            if (pop) begin
                d.rd = step(q.rd);
            end
            d.cnt = q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/spc_match.sv
module spc_match
    import spc_pkg::*;
(
    input  store_t lhs,
    input  store_t rhs,
    output logic   same
);
    logic addr_eq, data_eq, be_eq;

    always_comb begin
        addr_eq = (lhs.addr == rhs.addr);
        data_eq = (lhs.data == rhs.data);
        be_eq   = (lhs.be   == rhs.be);
        same    = addr_eq && data_eq && be_eq;
    end
endmodule

// File: rtl/store_pair_checker.sv
module store_pair_checker
    import spc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic [BE_W-1:0]   a_be,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    input  logic [BE_W-1:0]   b_be,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    input  logic              ckpt_req,
    output logic              ckpt_grant,
    output logic              rollback,
    input  logic              restore_done,
    output logic [CNT_W-1:0]  fault_count
);
    localparam int NSIDE = 2;

    typedef struct packed {
        guard_state_e     state;
        logic             pulse;
        logic [CNT_W-1:0] faults;
    } ctl_t;

    ctl_t q, d;

    store_t st_in [NSIDE];
    store_t st_hd [NSIDE];
    logic   valid_in [NSIDE];
    logic   rdy      [NSIDE];
    logic   push     [NSIDE];
    logic   empty    [NSIDE];
    logic   full     [NSIDE];
    logic   pop, flush, both, same, run, clash;

    assign st_in[0]    = '{addr: a_addr, data: a_data, be: a_be};
    assign st_in[1]    = '{addr: b_addr, data: b_data, be: b_be};
    assign valid_in[0] = a_valid;
    assign valid_in[1] = b_valid;

    assign run   = (q.state == S_RUN);
    assign both  = !empty[0] && !empty[1];
    assign clash = run && both && !same;
    assign flush = clash;

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        assign rdy[i]  = run && !full[i] && !clash;
        assign push[i] = valid_in[i] && rdy[i];

        spc_fifo #(.DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[i]),
            .din   (st_in[i]),
            .pop   (pop),
            .flush (flush),
            .head  (st_hd[i]),
            .empty (empty[i]),
            .full  (full[i])
        );
    end

    spc_match u_cmp (
        .lhs  (st_hd[0]),
        .rhs  (st_hd[1]),
        .same (same)
    );

    assign mem_valid  = run && both && same;
    assign pop        = mem_valid && mem_ready;
    assign mem_addr   = st_hd[0].addr;
    assign mem_data   = st_hd[0].data;
    assign mem_be     = st_hd[0].be;
    assign a_ready    = rdy[0];
    assign b_ready    = rdy[1];
    assign ckpt_grant = ckpt_req && run && empty[0] && empty[1];
    assign rollback   = q.pulse;
    assign fault_count = q.faults;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (clash) begin
            d.state = S_HOLD;
            d.pulse = 1'b1;
            if (q.faults != '1) d.faults = q.faults + 1'b1;
        end else if (q.state == S_HOLD && restore_done) begin
            d.state = S_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: S_RUN, pulse: 1'b0, faults: '0};
        else        q <= d;
    end

    a_r3_commit_only_equal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (st_hd[0] == st_hd[1]));
    a_r3_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> !rollback);
    a_r6_closed_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> !a_ready && !b_ready && !mem_valid);
    a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_grant |-> !mem_valid && !rollback);
    a_r8_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> fault_count != '0);
endmodule

// File: tb/store_pair_checker_test.sv
module store_pair_checker_test;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int SW     = ADDR_W + DATA_W + BE_W;
    localparam int CNT_W  = 3;
    localparam int DEPTH  = 4;
    localparam int NRND   = 200;
    typedef logic [SW-1:0] st_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 1'b0, b_valid = 1'b0, mem_ready = 1'b1;
    logic ckpt_req = 1'b0, restore_done = 1'b0;
    logic [ADDR_W-1:0] a_addr = '0, b_addr = '0, mem_addr;
    logic [DATA_W-1:0] a_data = '0, b_data = '0, mem_data;
    logic [BE_W-1:0]   a_be = '0, b_be = '0, mem_be;
    logic a_ready, b_ready, mem_valid, ckpt_grant, rollback;
    logic [CNT_W-1:0] fault_count;

    int checks = 0, errors = 0, n_commit = 0, n_faults = 0;
    bit finished = 0;
    st_t exp_q[$];
    st_t rnd[NRND];

    always #2 clk = ~clk;

    store_pair_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_data(a_data), .a_be(a_be),
        .b_valid(b_valid), .b_ready(b_ready), .b_addr(b_addr), .b_data(b_data), .b_be(b_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .ckpt_req(ckpt_req), .ckpt_grant(ckpt_grant), .rollback(rollback),
        .restore_done(restore_done), .fault_count(fault_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic st_t make_store();
        return {$urandom(), $urandom(), BE_W'($urandom())};
    endfunction

    function automatic logic [CNT_W-1:0] sat_count(input int n);
        return (n >= (1 << CNT_W) - 1) ? '1 : CNT_W'(n);
    endfunction

    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            st_t got;
            got = {mem_addr, mem_data, mem_be};
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected commit", longint'(got[63:0]), 0);
            end else begin
                st_t want;
                want = exp_q.pop_front();
                check(got == want, "R3 commit content/order", longint'(got[63:0]), longint'(want[63:0]));
            end
            n_commit++;
        end
    end

    task automatic push_a(input st_t s);
        a_valid = 1'b1;
        {a_addr, a_data, a_be} = s;
        @(negedge clk);
        while (!a_ready) @(negedge clk);
        @(posedge clk); #1;
        a_valid = 1'b0;
    endtask

    task automatic push_b(input st_t s);
        b_valid = 1'b1;
        {b_addr, b_data, b_be} = s;
        @(negedge clk);
        while (!b_ready) @(negedge clk);
        @(posedge clk); #1;
        b_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) idle(1);
    endtask

    task automatic inject(input int kind);
        st_t x, y;
        x = make_store();
        y = x;
        case (kind)
            0: y[BE_W +: DATA_W] = x[BE_W +: DATA_W] ^ 32'h1;
            1: y[SW-1 -: ADDR_W] = x[SW-1 -: ADDR_W] ^ 32'h8000_0000;
            default: y[BE_W-1:0] = x[BE_W-1:0] ^ BE_W'(1);
        endcase
        push_a(x);
        push_b(y);
        n_faults++;
        @(negedge clk);
        check(mem_valid == 1'b0, "R4 no commit on difference", mem_valid, 0);
        @(negedge clk);
        check(rollback == 1'b1, "R5 rollback pulse", rollback, 1);
        check(!a_ready && !b_ready, "R6 channels closed", {a_ready, b_ready}, 0);
        check(fault_count == sat_count(n_faults), "R8 fault count", fault_count, sat_count(n_faults));
        @(negedge clk);
        check(rollback == 1'b0, "R5 pulse one cycle", rollback, 0);
        a_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!a_ready && !b_ready && !mem_valid, "R6 held until restore",
                  {a_ready, b_ready, mem_valid}, 0);
        end
        a_valid = 1'b0;
        @(posedge clk); #1;
        restore_done = 1'b1;
        @(posedge clk); #1;
        restore_done = 1'b0;
        @(negedge clk);
        check(a_ready && b_ready, "R6 resumes after restore", {a_ready, b_ready}, 2'b11);
        ckpt_req = 1'b1;
        #0.5;
        check(ckpt_grant == 1'b1, "R4 queues emptied", ckpt_grant, 1);
        ckpt_req = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(a_ready && b_ready, "R1 ready after reset", {a_ready, b_ready}, 2'b11);
        check(!mem_valid && !rollback, "R1 quiet outputs", {mem_valid, rollback}, 0);
        check(fault_count == '0, "R1 count zero", fault_count, 0);
        @(posedge clk); #1;

        // R9 / R2: core A runs ahead by DEPTH stores
        begin
            st_t ahead[DEPTH];
            for (int i = 0; i < DEPTH; i++) begin
                ahead[i] = make_store();
                exp_q.push_back(ahead[i]);
                push_a(ahead[i]);
            end
            @(negedge clk);
            check(a_ready == 1'b0, "R2 full side not ready", a_ready, 0);
            check(b_ready == 1'b1, "R2 other side ready", b_ready, 1);
            check(mem_valid == 1'b0, "R9 no early commit", mem_valid, 0);
            ckpt_req = 1'b1;
            #0.5;
            check(ckpt_grant == 1'b0, "R7 no grant with pending", ckpt_grant, 0);
            ckpt_req = 1'b0;
            @(posedge clk); #1;
            for (int i = 0; i < DEPTH; i++) push_b(ahead[i]);
            drain();
            check(n_commit == DEPTH, "R9 all held stores committed", n_commit, DEPTH);
        end

        // R3: random streams with independent gaps and back-pressure
        for (int i = 0; i < NRND; i++) begin
            rnd[i] = make_store();
            exp_q.push_back(rnd[i]);
        end
        fork
            for (int i = 0; i < NRND; i++) begin
                idle($urandom_range(0, 3));
                push_a(rnd[i]);
            end
            for (int i = 0; i < NRND; i++) begin
                idle($urandom_range(0, 5));
                push_b(rnd[i]);
            end
            for (int i = 0; i < 1500; i++) begin
                mem_ready = ($urandom_range(0, 3) != 0);
                idle(1);
            end
        join_any
        mem_ready = 1'b1;
        drain();
        check(n_commit == DEPTH + NRND, "R3 every pair committed", n_commit, DEPTH + NRND);
        check(fault_count == '0, "R8 no count for equal stores", fault_count, 0);

        @(negedge clk);
        ckpt_req = 1'b1;
        #0.5;
        check(ckpt_grant == 1'b1, "R7 grant when empty", ckpt_grant, 1);
        ckpt_req = 1'b0;
        @(posedge clk); #1;

        // R4 / R5 / R6 / R8: faults in each field, past saturation
        for (int f = 0; f < 9; f++) inject(f % 3);
        check(fault_count == '1, "R8 saturated", fault_count, 7);
        check(n_commit == DEPTH + NRND, "R4 nothing committed on faults", n_commit, DEPTH + NRND);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule